// File: doc/BRIEF.md
# Chainable Serial Sample Output Port

This block drives the serial output of a six-channel sampling device that can share one receiver with up to seven identical devices wired in a chain. On a sample strobe it captures every channel value and the channel-enable mask. It then plays out one round per enabled channel, lowest index first. In each round the device raises its output frame-sync for one clock and sends its own 16-bit word, MSB first, over the next 16 clocks.

The serial data and frame-sync inputs of a device come from the outputs of its upstream neighbour. Both inputs pass through a 16-stage shift path, so an upstream word reaches the output exactly one word-time later. In each round the device nearest the receiver therefore sends first, and the words of the devices further up the chain follow back to back behind it. A 3-bit count register holds the number of chained devices minus one, which sets the round length to 16 × devices + 1 clocks. Every device in a chain must receive the same count, the same mask and the same strobe.

Top module: `casc_sample_port`

## Requirements
- R1: After reset, ser_out and fs_out are 0. The count register reads 0, so without a count write every round lasts 17 clocks.
- R2: A write (cnt_wr high at a clock edge) loads cnt_wdata, which is the number of devices minus one. A later strobe captures it, and each round then lasts 16 × (count + 1) + 1 clocks.
- R3: In round-relative clock 0, fs_out is 1. In clocks 1 to 16, ser_out carries the device's own word for that channel, bit 15 first and bit 0 last.
- R4: Rounds run only for channels whose mask bit was 1 at the strobe, in ascending channel index. A disabled channel produces no frame-sync and no word.
- R5: A strobe captures all six words from samples (channel c in bits 16c+15 to 16c) and the mask. The sequence then starts in the next clock from the lowest enabled channel, even if an earlier sequence was still running. Changes to samples or ch_en after the strobe have no effect on that sequence.
- R6: Outside its own 16 data clocks, ser_out equals ser_in from 16 clocks earlier. fs_out is the OR of the own round-start pulse and fs_in from 16 clocks earlier.
- R7: With two chained devices, count 1 and a common strobe, the last device outputs its own channel word first. The upstream device's frame-sync follows at round clock 16, and its word follows in clocks 17 to 32, for each enabled channel in turn.
- R8: After the round of the highest enabled channel, the device stops producing frame-syncs of its own. A strobe with an all-zero mask starts no sequence.
- R9: A count write during a running sequence does not change the round length of that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Captures samples and mask and starts a sequence |
| samples | input | 96 | Six 16-bit channel words, channel c at bits 16c+15 to 16c |
| ch_en | input | 6 | Channel-enable mask, bit c enables channel c |
| cnt_wr | input | 1 | Write strobe for the device-count register |
| cnt_wdata | input | 3 | Devices in chain minus one |
| ser_in | input | 1 | Serial data from the upstream device |
| fs_in | input | 1 | Frame-sync from the upstream device |
| ser_out | output | 1 | Serial data toward the receiver |
| fs_out | output | 1 | Frame-sync toward the receiver |

## Verification
The assertions check the sequencer's state on every cycle:
- the round counter steps by one and never passes the round length;
- the active channel is always one that was enabled, and channels only rise from round to round;
- the sequence stops after the last enabled channel, and an all-zero strobe starts nothing;
- the captured words stay unchanged between strobes.

Only the bench scenarios show the following:
- the serial bit order on the wire;
- the interleaving of two real chained devices;
- the 16-clock forwarding delay;
- that inputs changed after a strobe have no effect;
- that a mid-sequence count write leaves the running sequence unchanged.

// File: rtl/casc_sample_port.sv
module casc_sample_port #(
  parameter int NCH = 6,
  parameter int W   = 16,
  parameter int CW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [NCH*W-1:0] samples,
  input  logic [NCH-1:0]   ch_en,
  input  logic             cnt_wr,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic             ser_in,
  input  logic             fs_in,
  output logic             ser_out,
  output logic             fs_out
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW  = $clog2(W * (2 ** CW) + 2);

  logic [CW-1:0]    cnt_q, cnt_lat;
  logic [NCH-1:0]   en_lat;
  logic [NCH*W-1:0] hold;
  logic             act;
  logic [PW-1:0]    pos;
  logic [CHW-1:0]   ch;
  logic [W-1:0]     dsr, fsr;
  logic [CHW:0]     first, nxt;
  logic [PW-1:0]    last_pos;
  logic [W-1:0]     word, sw;
  logic             own_dat;

  function automatic logic [CHW:0] pick(input logic [NCH-1:0] m, input int start);
    logic [CHW:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i] && i >= start) r = {1'b1, CHW'(i)};
    return r;
  endfunction

  assign first    = pick(ch_en, 0);
  assign nxt      = pick(en_lat, int'(ch) + 1);
  assign last_pos = PW'(W) * (PW'(cnt_lat) + PW'(1));
  assign word     = hold[int'(ch)*W +: W];
  assign sw       = word << (pos - PW'(1));
  assign own_dat  = act && (pos != '0) && (pos <= PW'(W));
  assign ser_out  = own_dat ? sw[W-1] : dsr[W-1];
  assign fs_out   = (act && pos == '0) | fsr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cnt_lat <= '0;
      en_lat  <= '0;
      hold    <= '0;
      act     <= 1'b0;
      pos     <= '0;
      ch      <= '0;
      dsr     <= '0;
      fsr     <= '0;
    end else begin
      dsr <= {dsr[W-2:0], ser_in};
      fsr <= {fsr[W-2:0], fs_in};
      if (cnt_wr) cnt_q <= cnt_wdata;
      if (sample_stb) begin
        hold    <= samples;
        en_lat  <= ch_en;
        cnt_lat <= cnt_q;
        act     <= first[CHW];
        ch      <= first[CHW-1:0];
        pos     <= '0;
      end else if (act) begin
        if (pos == last_pos) begin
          act <= nxt[CHW];
          ch  <= nxt[CHW-1:0];
          pos <= '0;
        end else begin
          pos <= pos + PW'(1);
        end
      end
    end
  end
endmodule

module casc_sample_port_chk #(
  parameter int NCH = 6,
  parameter int W   = 16,
  parameter int CHW = 3,
  parameter int PW  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   en_lat,
  input logic [NCH*W-1:0] hold,
  input logic             act,
  input logic [PW-1:0]    pos,
  input logic [CHW-1:0]   ch,
  input logic [PW-1:0]    last_pos,
  input logic             nxt_found
);
  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb && (|ch_en) |=> act && pos == '0 && en_lat == $past(ch_en));
  p_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb && !(|ch_en) |=> !act);
  p_ch_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> en_lat[ch]);
  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> pos <= last_pos);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb && act && pos != last_pos |=> act && pos == $past(pos) + 1'b1);
  p_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb && act && pos == last_pos && nxt_found |=> act && pos == '0 && ch > $past(ch));
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb && act && pos == last_pos && !nxt_found |=> !act);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(hold));
endmodule

bind casc_sample_port casc_sample_port_chk #(.NCH(NCH), .W(W), .CHW(CHW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .ch_en(ch_en), .en_lat(en_lat),
  .hold(hold), .act(act), .pos(pos), .ch(ch), .last_pos(last_pos), .nxt_found(nxt[CHW])
);

// File: tb/casc_sample_port_tb_top.sv
module casc_sample_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_dn = 1'b0, stb_up = 1'b0;
  logic [95:0] smp_dn = '0, smp_up = '0;
  logic [5:0] mask = '0;
  logic cnt_wr = 1'b0;
  logic [2:0] cnt_wdata = '0;
  logic up_sd, up_fs, ser_out, fs_out;

  int total = 0, bad = 0;
  logic [15:0] sd [6];
  logic [15:0] su [6];
  logic [5:0] m;
  int cnt = 0;
  bit up_on;

  always #2 clk = ~clk;

  casc_sample_port up_i (
    .clk(clk), .rst_n(rst_n), .sample_stb(stb_up), .samples(smp_up), .ch_en(mask),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ser_in(1'b0), .fs_in(1'b0),
    .ser_out(up_sd), .fs_out(up_fs));

  casc_sample_port dut_i (
    .clk(clk), .rst_n(rst_n), .sample_stb(stb_dn), .samples(smp_dn), .ch_en(mask),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ser_in(up_sd), .fs_in(up_fs),
    .ser_out(ser_out), .fs_out(fs_out));

  task automatic chk(input bit ok, input string req, input int t, input logic [1:0] got, input logic [1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0d got fs,sd=%b expected %b", req, t, got, exp);
    end
  endtask

  function automatic logic [1:0] model(input int t);
    int len, tt, p;
    logic f, d;
    len = 16 * (cnt + 1) + 1;
    tt = t;
    for (int c = 0; c < 6; c++) begin
      if (m[c]) begin
        if (tt < len) begin
          p = tt;
          f = (p == 0);
          d = 1'b0;
          if (p >= 1 && p <= 16) d = sd[c][16-p];
          else if (up_on && cnt >= 1 && p >= 17 && p <= 32) d = su[c][32-p];
          if (up_on && cnt >= 1 && p == 16) f = 1'b1;
          return {f, d};
        end
        tt -= len;
      end
    end
    return 2'b00;
  endfunction

  function automatic int seq_len();
    int n = 0;
    for (int c = 0; c < 6; c++) if (m[c]) n += 16 * (cnt + 1) + 1;
    return n;
  endfunction

  task automatic write_cnt(input int v);
    cnt_wr = 1'b1;
    cnt_wdata = 3'(v);
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  // cut > 0: stop after cut cycles (restart). midw >= 0: count write at cycle 5.
  task automatic scen(input logic [5:0] mi, input int ci, input bit upi, input int cut,
                      input int midw, input string req);
    int n;
    logic [1:0] e, g;
    if (ci != cnt) begin
      write_cnt(ci);
      cnt = ci;
    end
    m = mi;
    up_on = upi;
    for (int c = 0; c < 6; c++) begin
      sd[c] = 16'($urandom);
      su[c] = 16'($urandom);
      smp_dn[c*16 +: 16] = sd[c];
      smp_up[c*16 +: 16] = su[c];
    end
    mask = mi;
    stb_dn = 1'b1;
    stb_up = upi;
    @(negedge clk);
    stb_dn = 1'b0;
    stb_up = 1'b0;
    smp_dn = {$urandom, $urandom, $urandom};
    smp_up = {$urandom, $urandom, $urandom};
    mask = 6'($urandom);
    n = (cut > 0) ? cut : seq_len() + 20;
    for (int t = 0; t < n; t++) begin
      if (midw >= 0 && t == 5) cnt_wr = 1'b1;
      if (midw >= 0 && t == 5) cnt_wdata = 3'(midw);
      e = model(t);
      g = {fs_out, ser_out};
      chk(g === e, req, t, g, e);
      @(negedge clk);
      if (midw >= 0 && t == 5) cnt_wr = 1'b0;
    end
    if (midw >= 0) cnt = midw;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk({fs_out, ser_out} === 2'b00, "R1", i, {fs_out, ser_out}, 2'b00);
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk({fs_out, ser_out} === 2'b00, "R1", 0, {fs_out, ser_out}, 2'b00);
    // no count write yet: 17-clock rounds
    scen(6'b111111, 0, 1'b0, 0, -1, "R1 R3 R4 R5");
    scen(6'b100101, 0, 1'b0, 0, -1, "R3 R4 R8");
    scen(6'b000000, 0, 1'b0, 0, -1, "R8");
    scen(6'b000001, 2, 1'b0, 0, -1, "R2 R6");
    scen(6'b010010, 1, 1'b1, 0, -1, "R7 R6 R4");
    scen(6'b111111, 1, 1'b1, 0, -1, "R7 R2");
    scen(6'b100000, 7, 1'b1, 0, -1, "R2 R7");
    // restart mid-sequence
    scen(6'b011110, 0, 1'b0, 23, -1, "R5");
    scen(6'b110001, 0, 1'b0, 0, -1, "R5 R4");
    // count write during running sequence
    scen(6'b001011, 1, 1'b1, 0, 4, "R9");
    scen(6'b000101, 4, 1'b1, 0, -1, "R9 R2");
    for (int k = 0; k < 14; k++) begin
      int c;
      logic [5:0] mm;
      c = int'($urandom % 8);
      mm = 6'($urandom);
      if (k % 4 == 0) mm = 6'b000000;
      scen(mm, c, (c >= 1) && ($urandom % 2 == 1), 0, -1, "R2 R3 R4 R6 R7");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule